// File: doc/BRIEF.md
# Power Domain and Module State Sequencer

This block holds the requested power and clock state of a set of peripheral modules that are grouped into power domains. It carries out the transitions between those states. Software reaches it over a plain 32-bit register bus with a write strobe and a combinational read port. For each module, software writes a target state and a local-reset-release flag. It then starts a domain transition by writing a command bit and polls a per-domain busy bit until that bit clears. When the transition completes, every module in the domain takes its requested state. The block drives each module's clock enable and active-low reset from that state.

A domain that is powered off, and that software has asked to power up, must first complete a handshake with an external power switch. The block raises a power-request bit for the domain and stalls. Software confirms good power by setting a flag in the domain control register. The domain is then marked on and the module transition runs. Every module transition takes a fixed, parameterized number of cycles, so the busy bit is always visible to software.

Module m belongs to domain m mod NUM_DOMAINS. Register locations are: command 0x000, busy 0x004, power request 0x008, domain control 0x100+4·d, domain status 0x200+4·d, module control 0x400+4·m and module status 0x800+4·m.

Top module: `pdm_ctrl`

## Requirements
- R1: After reset, every module status reads 0 (state 0, not clocked) and every module control reads 0x0000_0100 (reset released, next state 0). Domain status, busy and power request all read 0, and every modClkEn and modRstN bit is 0.
- R2: Module control keeps the next state in bits [1:0], the reset-release flag in bit 8 and the force flag in bit 31, and reads all other bits as 0. Writes to module status, domain status, busy or power-request locations change nothing.
- R3: A command write with bit d set, sent to an idle domain that is on, makes busy bit d read 1 from the next cycle. The bit stays 1 for exactly XFER_CYCLES cycles, and module status changes on the same edge that clears it.
- R4: Consider a domain whose status bit 0 reads 0 and whose control bit 0 is 1. A command for it sets power-request bit d and keeps busy set, with no module change, until software writes 1 to bit 8 of the domain control. Domain status then reads 1, the request clears and the module transition runs. If control bit 0 is 0, an off domain skips the handshake, stays off and still moves its modules.
- R5: On completion of domain d, each module with m mod NUM_DOMAINS = d loads its requested next state into status bits [1:0], and modules of other domains keep their state. Encodings: 0 software-reset-disable, 1 sync-reset, 2 disable, 3 enable.
- R6: Module status bit 12 and modClkEn[m] are 1 exactly when the module state is 1 or 3.
- R7: modRstN[m] is 1 exactly when control bit 8 of that module is 1 and its state is 2 or 3. A write to bit 8 takes effect one cycle after the write, with no command needed.
- R8: A command for a domain whose busy bit is 1 is ignored, including on the cycle in which that domain completes. The completion time does not move and no second transition follows.
- R9: Completion uses the next state held before the completing edge. A module control write that lands on that edge affects only a later transition.
- R10: One command write with several domain bits set starts all of those idle domains in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address within the 4 KB window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| modClkEn | output | NUM_MODULES | Per-module clock enable |
| modRstN | output | NUM_MODULES | Per-module active-low reset |

## Verification
Two kinds of event can land on a domain's completing edge: a command write to that same domain, and a control write to one of its modules. The bench lines up each one with the commit edge by counting negative edges from the command that started the transition. It then checks three results: busy falls on schedule and stays low, the committed state is the value held before the edge, and the new control value is read back without having been applied. A multi-bit command that starts two domains at once is checked the same way, along with a re-command sent one and two cycles into a busy window.

// File: rtl/pdm_pkg.sv
`timescale 1ns/1ps
package pdm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_PWR = 2'd1,
    PH_XFER     = 2'd2
  } domPhase_t;

  // per-domain strobes from the sequencer to the register datapath
  typedef struct packed {
    logic powerUp;
    logic commit;
  } seqStrobe_t;

  localparam logic [3:0] PAGE_GLOBAL = 4'h0;
  localparam logic [3:0] PAGE_DCTL   = 4'h1;
  localparam logic [3:0] PAGE_DSTAT  = 4'h2;
  localparam logic [1:0] BANK_MCTL   = 2'b01;
  localparam logic [1:0] BANK_MSTAT  = 2'b10;

  localparam logic [5:0] GREG_CMD    = 6'd0;
  localparam logic [5:0] GREG_BUSY   = 6'd1;
  localparam logic [5:0] GREG_PWRREQ = 6'd2;

  localparam int BIT_DNEXT = 0;
  localparam int BIT_PGOOD = 8;
  localparam int BIT_LRSTN = 8;
  localparam int BIT_FORCE = 31;
endpackage

// File: rtl/pdm_seq.sv
`timescale 1ns/1ps
module pdm_seq
  import pdm_pkg::*;
#(
  parameter int ND          = 2,
  parameter int XFER_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic       [ND-1:0]   cmdHit,
  input  logic       [ND-1:0]   domNext,
  input  logic       [ND-1:0]   domPgood,
  input  logic       [ND-1:0]   domOn,
  output logic       [ND-1:0]   busy,
  output logic       [ND-1:0]   pwrReq,
  output seqStrobe_t [ND-1:0]   strb
);
  localparam int             CW   = $clog2(XFER_CYCLES + 1);
  localparam logic [CW-1:0]  LOAD = CW'(XFER_CYCLES - 1);

  for (genvar d = 0; d < ND; d++) begin : g_dom
    domPhase_t     phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (cmdHit[d]) begin
              if (!domOn[d] && domNext[d]) begin
                phase <= PH_WAIT_PWR;
              end else begin
                phase <= PH_XFER;
                cnt   <= LOAD;
              end
            end
          end
          PH_WAIT_PWR: begin
            if (domPgood[d]) begin
              phase <= PH_XFER;
              cnt   <= LOAD;
            end
          end
          PH_XFER: begin
            if (cnt == '0) phase <= PH_IDLE;
            else           cnt   <= cnt - CW'(1);
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end

    assign busy[d]   = (phase != PH_IDLE);
    assign pwrReq[d] = (phase == PH_WAIT_PWR);
    assign strb[d]   = '{powerUp: (phase == PH_WAIT_PWR) && domPgood[d],
                         commit:  (phase == PH_XFER) && (cnt == '0)};
  end
endmodule

// File: rtl/pdm_regs.sv
`timescale 1ns/1ps
module pdm_regs
  import pdm_pkg::*;
#(
  parameter int ND = 2,
  parameter int NM = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic      [11:0]     regAddr,
  input  logic      [31:0]     regWdata,
  output logic      [31:0]     regRdata,
  input  logic      [ND-1:0]   busy,
  input  logic      [ND-1:0]   pwrReq,
  input  seqStrobe_t [ND-1:0]  strb,
  output logic      [ND-1:0]   cmdHit,
  output logic      [ND-1:0]   domNext,
  output logic      [ND-1:0]   domPgood,
  output logic      [ND-1:0]   domOn,
  output logic      [NM-1:0]   modClkEn,
  output logic      [NM-1:0]   modRstN
);
  logic [5:0] domIdx;
  logic [7:0] modIdx;
  logic       gPage, dcPage, dsPage, mcBank, msBank;

  assign domIdx = regAddr[7:2];
  assign modIdx = regAddr[9:2];
  assign gPage  = (regAddr[11:8] == PAGE_GLOBAL);
  assign dcPage = (regAddr[11:8] == PAGE_DCTL);
  assign dsPage = (regAddr[11:8] == PAGE_DSTAT);
  assign mcBank = (regAddr[11:10] == BANK_MCTL);
  assign msBank = (regAddr[11:10] == BANK_MSTAT);

  logic unusedBits;
  assign unusedBits = ^{regWdata, regAddr[1:0]};

  logic [ND-1:0] dNextQ, dPgoodQ, dOnQ;
  logic [ND-1:0] commitVec, powerUpVec;
  logic [NM-1:0][1:0] mNextQ, mStateQ;
  logic [NM-1:0] mLrstNQ, mForceQ;

  for (genvar d = 0; d < ND; d++) begin : g_unpack
    assign commitVec[d]  = strb[d].commit;
    assign powerUpVec[d] = strb[d].powerUp;
  end

  assign cmdHit   = (regWe && gPage && domIdx == GREG_CMD) ? regWdata[ND-1:0] : '0;
  assign domNext  = dNextQ;
  assign domPgood = dPgoodQ;
  assign domOn    = dOnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dNextQ  <= '0;
      dPgoodQ <= '0;
      dOnQ    <= '0;
      mNextQ  <= '0;
      mStateQ <= '0;
      mLrstNQ <= '1;
      mForceQ <= '0;
    end else begin
      for (int d = 0; d < ND; d++) begin
        if (regWe && dcPage && domIdx == 6'(d)) begin
          dNextQ[d]  <= regWdata[BIT_DNEXT];
          dPgoodQ[d] <= regWdata[BIT_PGOOD];
        end
        if (powerUpVec[d]) dOnQ[d] <= 1'b1;
      end
      for (int m = 0; m < NM; m++) begin
        if (regWe && mcBank && modIdx == 8'(m)) begin
          mNextQ[m]  <= regWdata[1:0];
          mLrstNQ[m] <= regWdata[BIT_LRSTN];
          mForceQ[m] <= regWdata[BIT_FORCE];
        end
        // commit sees the control value held before this edge
        if (commitVec[m % ND]) mStateQ[m] <= mNextQ[m];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (gPage) begin
      if (domIdx == GREG_BUSY)        regRdata = 32'(busy);
      else if (domIdx == GREG_PWRREQ) regRdata = 32'(pwrReq);
    end
    for (int d = 0; d < ND; d++) begin
      if (dcPage && domIdx == 6'(d)) regRdata = {23'b0, dPgoodQ[d], 7'b0, dNextQ[d]};
      if (dsPage && domIdx == 6'(d)) regRdata = {31'b0, dOnQ[d]};
    end
    for (int m = 0; m < NM; m++) begin
      if (mcBank && modIdx == 8'(m))
        regRdata = {mForceQ[m], 22'b0, mLrstNQ[m], 6'b0, mNextQ[m]};
      if (msBank && modIdx == 8'(m))
        regRdata = {19'b0, mStateQ[m][0], 10'b0, mStateQ[m]};
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_mod
    assign modClkEn[m] = mStateQ[m][0];
    assign modRstN[m]  = mLrstNQ[m] & mStateQ[m][1];
  end
endmodule

// File: rtl/pdm_ctrl.sv
`timescale 1ns/1ps
module pdm_ctrl
  import pdm_pkg::*;
#(
  parameter int NUM_DOMAINS = 2,
  parameter int NUM_MODULES = 4,
  parameter int XFER_CYCLES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [11:0]            regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  output logic [NUM_MODULES-1:0] modClkEn,
  output logic [NUM_MODULES-1:0] modRstN
);
  logic       [NUM_DOMAINS-1:0] cmdHit, domNext, domPgood, domOn, busy, pwrReq;
  seqStrobe_t [NUM_DOMAINS-1:0] strb;

  pdm_seq #(.ND(NUM_DOMAINS), .XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .cmdHit   (cmdHit),
    .domNext  (domNext),
    .domPgood (domPgood),
    .domOn    (domOn),
    .busy     (busy),
    .pwrReq   (pwrReq),
    .strb     (strb)
  );

  pdm_regs #(.ND(NUM_DOMAINS), .NM(NUM_MODULES)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busy     (busy),
    .pwrReq   (pwrReq),
    .strb     (strb),
    .cmdHit   (cmdHit),
    .domNext  (domNext),
    .domPgood (domPgood),
    .domOn    (domOn),
    .modClkEn (modClkEn),
    .modRstN  (modRstN)
  );
endmodule

// File: rtl/pdm_ctrl_chk.sv
`timescale 1ns/1ps
module pdm_ctrl_chk
  import pdm_pkg::*;
#(
  parameter int ND = 2,
  parameter int NM = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic       [ND-1:0]  cmdHit,
  input logic       [ND-1:0]  busy,
  input logic       [ND-1:0]  pwrReq,
  input logic       [ND-1:0]  domPgood,
  input logic       [ND-1:0]  domOn,
  input seqStrobe_t [ND-1:0]  strb,
  input logic       [NM-1:0]  modClkEn
);
  for (genvar d = 0; d < ND; d++) begin : g_dchk
    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
      $rose(busy[d]) |-> $past(cmdHit[d])); // R3
    AST_BUSY_ENDS_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
      $fell(busy[d]) |-> $past(strb[d].commit)); // R3
    AST_PWRREQ_NEEDS_PGOOD: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pwrReq[d]) |-> $past(domPgood[d])); // R4
    AST_DOM_ON_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(domOn[d]) |-> $past(pwrReq[d] && domPgood[d])); // R4
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (busy[d] && cmdHit[d] && !strb[d].commit) |=> busy[d]); // R8
  end

  for (genvar m = 0; m < NM; m++) begin : g_mchk
    AST_CLKEN_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(modClkEn[m]) |-> $past(strb[m % ND].commit)); // R5
  end
endmodule

bind pdm_ctrl pdm_ctrl_chk #(.ND(NUM_DOMAINS), .NM(NUM_MODULES)) u_chk (.*);

// File: tb/pdm_ctrl_tb.sv
`timescale 1ns/1ps
module pdm_ctrl_tb;
  localparam int ND = 2;
  localparam int NM = 4;
  localparam int XC = 3;
  localparam logic [11:0] A_CMD = 12'h000;
  localparam logic [11:0] A_BUSY = 12'h004;
  localparam logic [11:0] A_PREQ = 12'h008;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NM-1:0] modClkEn, modRstN;

  int checks = 0;
  int failures = 0;
  int nxt[NM];
  int lr[NM];
  int st[NM];
  logic [31:0] v;

  always #4 clk = ~clk;

  pdm_ctrl #(.NUM_DOMAINS(ND), .NUM_MODULES(NM), .XFER_CYCLES(XC)) u_dut (.*);

  function automatic logic [11:0] aDctl(int d);  return 12'(32'h100 + 4*d); endfunction
  function automatic logic [11:0] aDstat(int d); return 12'(32'h200 + 4*d); endfunction
  function automatic logic [11:0] aMctl(int m);  return 12'(32'h400 + 4*m); endfunction
  function automatic logic [11:0] aMstat(int m); return 12'(32'h800 + 4*m); endfunction
  function automatic logic [31:0] expStat(int s); return 32'(((s & 1) << 12) | s); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic peek(logic [11:0] a, output logic [31:0] r);
    regAddr = a; #1; r = regRdata;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] r);
    peek(a, r);
    @(negedge clk);
  endtask

  task automatic waitIdle();
    logic [31:0] r;
    for (int i = 0; i < 100; i++) begin
      rd(A_BUSY, r);
      if (r == 0) return;
    end
    chk("R3 busy never cleared", r, 32'h0);
  endtask

  task automatic setM(int m, int l, int n);
    wr(aMctl(m), 32'((l << 8) | n));
    nxt[m] = n; lr[m] = l;
  endtask

  task automatic commitModel(int mask);
    for (int m = 0; m < NM; m++)
      if (((mask >> (m % ND)) & 1) == 1) st[m] = nxt[m];
  endtask

  task automatic runCmd(int mask);
    wr(A_CMD, 32'(mask));
    waitIdle();
    commitModel(mask);
  endtask

  task automatic checkAll();
    logic [31:0] r;
    for (int m = 0; m < NM; m++) begin
      rd(aMstat(m), r);
      chk($sformatf("R5 status m=%0d", m), r, expStat(st[m]));
      chk($sformatf("R6 clkEn m=%0d", m), 32'(modClkEn[m]), 32'(st[m] & 1));
      chk($sformatf("R7 rstN m=%0d", m), 32'(modRstN[m]), 32'(lr[m] & (st[m] >> 1)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int m = 0; m < NM; m++) begin nxt[m] = 0; lr[m] = 1; st[m] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_BUSY, v); chk("R1 busy", v, 0);
    rd(A_PREQ, v); chk("R1 pwrReq", v, 0);
    for (int d = 0; d < ND; d++) begin rd(aDstat(d), v); chk("R1 dstat", v, 0); end
    for (int m = 0; m < NM; m++) begin
      rd(aMstat(m), v); chk("R1 mstat", v, 0);
      rd(aMctl(m), v);  chk("R1 mctl", v, 32'h100);
    end
    chk("R1 clkEn", 32'(modClkEn), 0);
    chk("R1 rstN", 32'(modRstN), 0);

    // R2 field storage and read-only locations
    wr(aMctl(3), 32'hFFFF_FFFF);
    rd(aMctl(3), v); chk("R2 mctl fields", v, 32'h8000_0103);
    wr(aMctl(3), 32'h100);
    wr(aMstat(3), 32'hFFFF_FFFF);
    rd(aMstat(3), v); chk("R2 mstat ro", v, 0);
    wr(A_BUSY, 32'hFFFF_FFFF);
    rd(A_BUSY, v); chk("R2 busy ro", v, 0);
    wr(A_PREQ, 32'hFFFF_FFFF);
    rd(A_PREQ, v); chk("R2 pwrReq ro", v, 0);
    wr(aDstat(0), 32'hFFFF_FFFF);
    rd(aDstat(0), v); chk("R2 dstat ro", v, 0);

    // R4 power-up handshake on domain 0
    setM(0, 1, 3);
    wr(aDctl(0), 32'h1);
    wr(A_CMD, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_PREQ, v);     chk("R4 request raised", v, 1);
    rd(A_BUSY, v);     chk("R4 busy while waiting", v, 1);
    rd(aDstat(0), v);  chk("R4 still off", v, 0);
    rd(aMstat(0), v);  chk("R4 no module change", v, 0);
    wr(aDctl(0), 32'h101);
    waitIdle();
    commitModel(1);
    rd(aDstat(0), v);  chk("R4 domain on", v, 1);
    rd(A_PREQ, v);     chk("R4 request cleared", v, 0);
    rd(aMstat(0), v);  chk("R4 module enabled", v, expStat(3));

    // R4 off domain with NEXT clear skips the handshake
    setM(1, 1, 2);
    wr(A_CMD, 32'h2);
    peek(A_PREQ, v);   chk("R4 no request", v, 0);
    waitIdle();
    commitModel(2);
    rd(aDstat(1), v);  chk("R4 stays off", v, 0);
    rd(aMstat(1), v);  chk("R4 module moved", v, expStat(2));

    // R3 exact busy window and commit edge
    setM(0, 1, 2);
    wr(A_CMD, 32'h1);
    for (int k = 1; k <= XC; k++) begin
      peek(A_BUSY, v);    chk($sformatf("R3 busy k=%0d", k), v, 1);
      peek(aMstat(0), v); chk($sformatf("R3 old state k=%0d", k), v, expStat(st[0]));
      @(negedge clk);
    end
    commitModel(1);
    peek(A_BUSY, v);    chk("R3 busy cleared", v, 0);
    peek(aMstat(0), v); chk("R3 new state", v, expStat(st[0]));
    @(negedge clk);

    // R8 re-commands during busy and on the commit edge
    setM(0, 1, 3);
    wr(A_CMD, 32'h1);
    peek(A_BUSY, v);   chk("R8 busy k=1", v, 1);
    wr(A_CMD, 32'h1);
    peek(A_BUSY, v);   chk("R8 busy k=2", v, 1);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h1);
    commitModel(1);
    peek(A_BUSY, v);   chk("R8 completion unchanged", v, 0);
    peek(aMstat(0), v); chk("R8 state", v, expStat(st[0]));
    repeat (3) @(negedge clk);
    peek(A_BUSY, v);   chk("R8 no relaunch", v, 0);
    @(negedge clk);

    // R9 control write on the commit edge
    setM(0, 1, 2);
    wr(A_CMD, 32'h1);
    repeat (XC - 1) @(negedge clk);
    wr(aMctl(0), 32'h103);
    commitModel(1);
    nxt[0] = 3;
    peek(A_BUSY, v);   chk("R9 done", v, 0);
    @(negedge clk);
    rd(aMstat(0), v);  chk("R9 old next committed", v, expStat(2));
    rd(aMctl(0), v);   chk("R9 new control kept", v, 32'h103);
    runCmd(1);
    rd(aMstat(0), v);  chk("R9 later transition", v, expStat(3));

    // R10 two domains started by one write
    setM(2, 1, 2);
    setM(1, 1, 3);
    wr(A_CMD, 32'h3);
    peek(A_BUSY, v);   chk("R10 both busy", v, 3);
    repeat (XC) @(negedge clk);
    peek(A_BUSY, v);   chk("R10 both done", v, 0);
    commitModel(3);
    @(negedge clk);
    rd(aMstat(2), v);  chk("R10 dom0 module", v, expStat(2));
    rd(aMstat(1), v);  chk("R10 dom1 module", v, expStat(3));

    // R7 local reset flag acts without a command
    wr(aMctl(0), 32'h003);
    chk("R7 local reset held", 32'(modRstN[0]), 0);
    wr(aMctl(0), 32'h103);
    chk("R7 local reset released", 32'(modRstN[0]), 1);

    // R5 R6 R7 sweep over modules, states and reset flag
    for (int m = 0; m < NM; m++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 2; l++) begin
          setM(m, l, s);
          runCmd(1 << (m % ND));
          checkAll();
        end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule